// File: doc/BRIEF.md
# Procedure Frame Enter/Leave Sequencer

This block carries out the stack work of a procedure prologue and epilogue for a processor core. When entering, it saves the caller's base pointer on the stack and takes the stack pointer that results as the new frame pointer. For a nonzero nesting depth it copies the outer frame pointers (the display) from the caller's frame onto the new frame, and then it pushes the new frame pointer itself. Last, it points the base pointer at the new frame and reserves local space by moving the stack pointer down by the frame size. When leaving, it moves the stack pointer back to the base pointer and pops the saved base pointer.

All memory traffic uses one request/acknowledge port, and only one access is in flight at a time. If an access ends with a fault, the sequence stops and both pointers go back to the values they had when the operation started. Each completed operation reports how many cycles it costs, and how many reads and writes it performed.

Top module: `frame_seq`

## Requirements
- R1: On enter, the block first writes the incoming base pointer at the stack pointer minus the operand size in bytes (2 when `op_wide`=0, 4 when `op_wide`=1). The stack pointer after that push becomes the frame pointer.
- R2: For a nesting level L greater than 1, the copy step runs L-1 times. Each pass lowers the base pointer by the operand size, reads memory at the lowered base pointer, and pushes the value it read.
- R3: When L is nonzero, the last push writes the frame pointer. When L is 0, no read takes place and the base pointer push is the only write. On success `wr_count` is L+1 (1 for L=0) and `rd_count` is L-1 (0 for L≤1).
- R4: At the end of enter, the base pointer takes the frame pointer, and the stack pointer is lowered by the 16-bit `frame_size`.
- R5: With `stk_wide`=0, stack pointer arithmetic changes only bits 15:0, and stack addresses are driven with bits 31:16 at zero. With `op_wide`=0, base pointer updates change only bits 15:0, base pointer read addresses have bits 31:16 at zero, and write data is zero-extended from 16 bits.
- R6: A faulting access ends the operation: `done` and `fault` pulse together, and `sp_out`/`bp_out` return to `sp_in`/`bp_in` as sampled at the start.
- R7: On a successful enter, `cycles` equals the base cost (14 when `fast_core`=1, otherwise 10), plus 3 or 4 for each copy pass, plus 3 or 5 for the frame pointer push when L is nonzero.
- R8: Leave sets the stack pointer to the base pointer (only bits 15:0 when `op_wide`=0). It then pops the base pointer from that address and raises the stack pointer by the operand size. `cycles` is 4. A faulting pop restores both pointers.
- R9: `mem_req` stays high with a stable `mem_addr` until `mem_ack`. `mem_we` is high only together with `mem_req`.
- R10: A `start` that arrives while an operation is in progress is ignored and does not change its result.
- R11: After reset, `done`, `fault` and `mem_req` are low and both pointer outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| op_leave | input | 1 | 0 = enter, 1 = leave |
| frame_size | input | 16 | Local space to reserve, in bytes |
| nest_level | input | 8 | Nesting depth L |
| op_wide | input | 1 | Operand size: 0 = 2 bytes, 1 = 4 bytes |
| stk_wide | input | 1 | Stack pointer width: 0 = 16-bit, 1 = 32-bit |
| fast_core | input | 1 | Selects the fast cycle cost table |
| sp_in | input | 32 | Stack pointer at start |
| bp_in | input | 32 | Base pointer at start |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Access address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Access complete |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_fault | input | 1 | Access faulted, valid with mem_ack |
| sp_out | output | 32 | Resulting stack pointer |
| bp_out | output | 32 | Resulting base pointer |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Completion was a fault |
| cycles | output | 16 | Cycle cost of the last successful operation |
| rd_count | output | 9 | Reads performed |
| wr_count | output | 9 | Writes performed |

## Verification
The bench aims at the nesting boundaries: levels 0, 1, 2 and 255. An off-by-one in the copy counter would show up there as one copy too many or too few, a missing frame pointer push, or a wrong cycle total. It moves the 16-bit stack pointer across zero, where a design that lets the borrow into bits 31:16 would corrupt the upper half or drive a wide address. It injects faults on the first push, in the middle of the copy loop and on the leave pop, and a design that rolled back only one pointer, or rolled back to the wrong values, would fail there. A second start fired in the middle of an enter checks that the running sequence is not restarted.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PUSH_BP,
        ST_READ,
        ST_PUSH_CP,
        ST_PUSH_FP,
        ST_FINISH,
        ST_POP
    } seq_st_e;

    // Cycle cost components: fast table and standard table
    localparam int COST_BASE_FAST = 14;
    localparam int COST_BASE_STD  = 10;
    localparam int COST_ITER_FAST = 3;
    localparam int COST_ITER_STD  = 4;
    localparam int COST_TAIL_FAST = 3;
    localparam int COST_TAIL_STD  = 5;
    localparam int COST_LEAVE     = 4;

endpackage

// File: rtl/frame_ptr_alu.sv
module frame_ptr_alu #(
    parameter int PTR_W  = 32,
    parameter int SIZE_W = 16
) (
    input  logic [PTR_W-1:0]  sp,
    input  logic [PTR_W-1:0]  bp,
    input  logic              op_wide,
    input  logic              stk_wide,
    input  logic [SIZE_W-1:0] frame_size,
    output logic [PTR_W-1:0]  sp_push,
    output logic [PTR_W-1:0]  sp_pop,
    output logic [PTR_W-1:0]  sp_alloc,
    output logic [PTR_W-1:0]  bp_step,
    output logic [PTR_W-1:0]  addr_cur,
    output logic [PTR_W-1:0]  addr_push,
    output logic [PTR_W-1:0]  addr_step
);
    localparam int HALF = PTR_W / 2;

    logic [PTR_W-1:0] nbytes;
    logic [PTR_W-1:0] size_ext;

    assign nbytes   = op_wide ? PTR_W'(PTR_W / 8) : PTR_W'(PTR_W / 16);
    assign size_ext = {{(PTR_W-SIZE_W){1'b0}}, frame_size};

    function automatic logic [PTR_W-1:0] merge_lo(input logic [PTR_W-1:0] old_v,
                                                  input logic [PTR_W-1:0] new_v,
                                                  input logic             wide);
        return wide ? new_v : {old_v[PTR_W-1:HALF], new_v[HALF-1:0]};
    endfunction

    function automatic logic [PTR_W-1:0] narrow(input logic [PTR_W-1:0] v,
                                                input logic             wide);
        return wide ? v : {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    assign sp_push   = merge_lo(sp, sp - nbytes,   stk_wide);
    assign sp_pop    = merge_lo(sp, sp + nbytes,   stk_wide);
    assign sp_alloc  = merge_lo(sp, sp - size_ext, stk_wide);
    assign bp_step   = merge_lo(bp, bp - nbytes,   op_wide);
    assign addr_cur  = narrow(sp, stk_wide);
    assign addr_push = narrow(sp_push, stk_wide);
    assign addr_step = narrow(bp_step, op_wide);

endmodule

// File: rtl/frame_cost.sv
module frame_cost
    import frame_seq_pkg::*;
#(
    parameter int CYC_W = 16
) (
    input  logic             fast_core,
    output logic [CYC_W-1:0] cost_base,
    output logic [CYC_W-1:0] cost_iter,
    output logic [CYC_W-1:0] cost_tail,
    output logic [CYC_W-1:0] cost_leave
);
    assign cost_base  = fast_core ? CYC_W'(COST_BASE_FAST) : CYC_W'(COST_BASE_STD);
    assign cost_iter  = fast_core ? CYC_W'(COST_ITER_FAST) : CYC_W'(COST_ITER_STD);
    assign cost_tail  = fast_core ? CYC_W'(COST_TAIL_FAST) : CYC_W'(COST_TAIL_STD);
    assign cost_leave = CYC_W'(COST_LEAVE);
endmodule

// File: rtl/frame_seq.sv
module frame_seq
    import frame_seq_pkg::*;
#(
    parameter int PTR_W  = 32,
    parameter int SIZE_W = 16,
    parameter int LVL_W  = 8,
    parameter int CYC_W  = 16,
    localparam int CNT_W = LVL_W + 1,
    localparam int HALF  = PTR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              op_leave,
    input  logic [SIZE_W-1:0] frame_size,
    input  logic [LVL_W-1:0]  nest_level,
    input  logic              op_wide,
    input  logic              stk_wide,
    input  logic              fast_core,
    input  logic [PTR_W-1:0]  sp_in,
    input  logic [PTR_W-1:0]  bp_in,
    output logic              mem_req,
    output logic              mem_we,
    output logic [PTR_W-1:0]  mem_addr,
    output logic [PTR_W-1:0]  mem_wdata,
    input  logic              mem_ack,
    input  logic [PTR_W-1:0]  mem_rdata,
    input  logic              mem_fault,
    output logic [PTR_W-1:0]  sp_out,
    output logic [PTR_W-1:0]  bp_out,
    output logic              done,
    output logic              fault,
    output logic [CYC_W-1:0]  cycles,
    output logic [CNT_W-1:0]  rd_count,
    output logic [CNT_W-1:0]  wr_count
);
    typedef struct packed {
        seq_st_e           state;
        logic [PTR_W-1:0]  sp;
        logic [PTR_W-1:0]  bp;
        logic [PTR_W-1:0]  sp0;
        logic [PTR_W-1:0]  bp0;
        logic [PTR_W-1:0]  fp;
        logic [PTR_W-1:0]  tmp;
        logic [LVL_W-1:0]  cnt;
        logic              opw;
        logic              stkw;
        logic              fast;
        logic [SIZE_W-1:0] size;
        logic [CYC_W-1:0]  cyc;
        logic [CNT_W-1:0]  rd;
        logic [CNT_W-1:0]  wr;
        logic              done;
        logic              fault;
    } seq_regs_t;

    seq_regs_t q, d;
    logic      busy;

    logic [PTR_W-1:0] sp_push, sp_pop, sp_alloc, bp_step;
    logic [PTR_W-1:0] addr_cur, addr_push, addr_step;
    logic [CYC_W-1:0] cost_base, cost_iter, cost_tail, cost_leave;

    frame_ptr_alu #(.PTR_W(PTR_W), .SIZE_W(SIZE_W)) alu_i (
        .sp(q.sp), .bp(q.bp), .op_wide(q.opw), .stk_wide(q.stkw),
        .frame_size(q.size),
        .sp_push(sp_push), .sp_pop(sp_pop), .sp_alloc(sp_alloc),
        .bp_step(bp_step), .addr_cur(addr_cur), .addr_push(addr_push),
        .addr_step(addr_step)
    );

    frame_cost #(.CYC_W(CYC_W)) cost_i (
        .fast_core(q.fast), .cost_base(cost_base), .cost_iter(cost_iter),
        .cost_tail(cost_tail), .cost_leave(cost_leave)
    );

    function automatic logic [PTR_W-1:0] zext_op(input logic [PTR_W-1:0] v,
                                                 input logic             wide);
        return wide ? v : {{HALF{1'b0}}, v[HALF-1:0]};
    endfunction

    function automatic logic [PTR_W-1:0] lo_only(input logic [PTR_W-1:0] old_v,
                                                 input logic [PTR_W-1:0] new_v,
                                                 input logic             wide);
        return wide ? new_v : {old_v[PTR_W-1:HALF], new_v[HALF-1:0]};
    endfunction

    assign busy = (q.state != ST_IDLE);

    always_comb begin
        d         = q;
        d.done    = 1'b0;
        d.fault   = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (q.state)
            ST_IDLE: begin
                if (start) begin
                    d.sp0  = sp_in;
                    d.bp0  = bp_in;
                    d.bp   = bp_in;
                    d.opw  = op_wide;
                    d.stkw = stk_wide;
                    d.fast = fast_core;
                    d.size = frame_size;
                    d.cnt  = nest_level;
                    d.cyc  = '0;
                    d.rd   = '0;
                    d.wr   = '0;
                    if (op_leave) begin
                        d.sp    = lo_only(sp_in, bp_in, op_wide);
                        d.state = ST_POP;
                    end else begin
                        d.sp    = sp_in;
                        d.state = ST_PUSH_BP;
                    end
                end
            end
            ST_PUSH_BP, ST_PUSH_CP, ST_PUSH_FP: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = addr_push;
                case (q.state)
                    ST_PUSH_BP: mem_wdata = zext_op(q.bp, q.opw);
                    ST_PUSH_CP: mem_wdata = q.tmp;
                    default:    mem_wdata = zext_op(q.fp, q.opw);
                endcase
                if (mem_ack && !mem_fault) begin
                    d.sp = sp_push;
                    d.wr = q.wr + 1'b1;
                    case (q.state)
                        ST_PUSH_BP: begin
                            d.fp  = sp_push;
                            d.cyc = cost_base;
                            if (q.cnt == '0)
                                d.state = ST_FINISH;
                            else if (q.cnt == LVL_W'(1))
                                d.state = ST_PUSH_FP;
                            else
                                d.state = ST_READ;
                            d.cnt = (q.cnt == '0) ? q.cnt : q.cnt - 1'b1;
                        end
                        ST_PUSH_CP: begin
                            d.cyc   = q.cyc + cost_iter;
                            d.cnt   = q.cnt - 1'b1;
                            d.state = (q.cnt == LVL_W'(1)) ? ST_PUSH_FP : ST_READ;
                        end
                        default: begin
                            d.cyc   = q.cyc + cost_tail;
                            d.state = ST_FINISH;
                        end
                    endcase
                end
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = addr_step;
                if (mem_ack && !mem_fault) begin
                    d.bp    = bp_step;
                    d.tmp   = zext_op(mem_rdata, q.opw);
                    d.rd    = q.rd + 1'b1;
                    d.state = ST_PUSH_CP;
                end
            end
            ST_FINISH: begin
                d.bp    = lo_only(q.bp, q.fp, q.opw);
                d.sp    = sp_alloc;
                d.done  = 1'b1;
                d.state = ST_IDLE;
            end
            ST_POP: begin
                mem_req  = 1'b1;
                mem_addr = addr_cur;
                if (mem_ack && !mem_fault) begin
                    d.bp    = lo_only(q.bp, mem_rdata, q.opw);
                    d.sp    = sp_pop;
                    d.rd    = q.rd + 1'b1;
                    d.cyc   = cost_leave;
                    d.done  = 1'b1;
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase
        // any faulting access rolls back both pointers
        if (mem_req && mem_ack && mem_fault) begin
            d.sp    = q.sp0;
            d.bp    = q.bp0;
            d.done  = 1'b1;
            d.fault = 1'b1;
            d.state = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sp_out   = q.sp;
    assign bp_out   = q.bp;
    assign done     = q.done;
    assign fault    = q.fault;
    assign cycles   = q.cyc;
    assign rd_count = q.rd;
    assign wr_count = q.wr;

endmodule

// File: rtl/frame_seq_chk.sv
module frame_seq_chk #(
    parameter int PTR_W = 32,
    parameter int LVL_W = 8,
    parameter int CYC_W = 16,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             op_leave,
    input logic [LVL_W-1:0] nest_level,
    input logic [PTR_W-1:0] sp_in,
    input logic [PTR_W-1:0] bp_in,
    input logic             busy,
    input logic             mem_req,
    input logic             mem_we,
    input logic             mem_ack,
    input logic [PTR_W-1:0] mem_addr,
    input logic [PTR_W-1:0] sp_out,
    input logic [PTR_W-1:0] bp_out,
    input logic             done,
    input logic             fault,
    input logic [CYC_W-1:0] cycles,
    input logic [CNT_W-1:0] rd_count,
    input logic [CNT_W-1:0] wr_count
);
    logic [PTR_W-1:0] rec_sp, rec_bp;
    logic [LVL_W-1:0] rec_lvl;
    logic             rec_leave;
    int               exp_wr, exp_rd;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_sp    <= '0;
            rec_bp    <= '0;
            rec_lvl   <= '0;
            rec_leave <= 1'b0;
        end else if (start && !busy) begin
            rec_sp    <= sp_in;
            rec_bp    <= bp_in;
            rec_lvl   <= nest_level;
            rec_leave <= op_leave;
        end
    end

    always_comb begin
        exp_wr = (rec_lvl == '0) ? 1 : int'(rec_lvl) + 1;
        exp_rd = (rec_lvl > LVL_W'(1)) ? int'(rec_lvl) - 1 : 0;
    end

    assert_fault_rollback_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (done && sp_out == rec_sp && bp_out == rec_bp));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_enter_counts_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && !rec_leave) |->
            (int'(wr_count) == exp_wr && int'(rd_count) == exp_rd));

    assert_leave_cost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !fault && rec_leave) |-> (cycles == CYC_W'(4) && rd_count == CNT_W'(1)));

    assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

    assert_we_with_req_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req);

endmodule

bind frame_seq frame_seq_chk #(
    .PTR_W(PTR_W), .LVL_W(LVL_W), .CYC_W(CYC_W), .CNT_W(CNT_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .start(start), .op_leave(op_leave),
    .nest_level(nest_level), .sp_in(sp_in), .bp_in(bp_in), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
    .sp_out(sp_out), .bp_out(bp_out), .done(done), .fault(fault),
    .cycles(cycles), .rd_count(rd_count), .wr_count(wr_count)
);

// File: tb/frame_seq_tb_top.sv
module frame_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        op_leave = 1'b0;
    logic [15:0] frame_size = '0;
    logic [7:0]  nest_level = '0;
    logic        op_wide = 1'b0;
    logic        stk_wide = 1'b0;
    logic        fast_core = 1'b0;
    logic [31:0] sp_in = '0;
    logic [31:0] bp_in = '0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        mem_fault = 1'b0;
    logic [31:0] sp_out, bp_out;
    logic        done, fault;
    logic [15:0] cycles;
    logic [8:0]  rd_count, wr_count;

    int n_tests = 0;
    int n_fail  = 0;
    int acc_idx = 0;
    int fault_at = -1;
    logic [31:0] act_wa[$];
    logic [31:0] act_wd[$];
    logic [31:0] exp_wa[$];
    logic [31:0] exp_wd[$];
    logic [31:0] exp_sp, exp_bp;
    int          exp_cyc, exp_rd, exp_wr;

    always #10 clk = ~clk;

    frame_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op_leave(op_leave),
        .frame_size(frame_size), .nest_level(nest_level), .op_wide(op_wide),
        .stk_wide(stk_wide), .fast_core(fast_core), .sp_in(sp_in), .bp_in(bp_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .mem_fault(mem_fault), .sp_out(sp_out), .bp_out(bp_out), .done(done),
        .fault(fault), .cycles(cycles), .rd_count(rd_count), .wr_count(wr_count)
    );

    function automatic logic [31:0] memval(input logic [31:0] a);
        return (a ^ 32'h5A3C_96E1) + (a << 7);
    endfunction

    // memory responder: one-cycle latency, ack for one cycle
    always @(negedge clk) begin
        if (mem_ack) begin
            mem_ack   = 1'b0;
            mem_fault = 1'b0;
        end else if (mem_req) begin
            mem_ack   = 1'b1;
            mem_fault = (acc_idx == fault_at);
            mem_rdata = memval(mem_addr);
            if (mem_we && !mem_fault) begin
                act_wa.push_back(mem_addr);
                act_wd.push_back(mem_wdata);
            end
            acc_idx++;
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish (actual hung, expected completion)");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] lo_keep(input logic [31:0] o, input logic [31:0] n,
                                            input logic w);
        return w ? n : {o[31:16], n[15:0]};
    endfunction

    function automatic logic [31:0] nar(input logic [31:0] v, input logic w);
        return w ? v : {16'h0, v[15:0]};
    endfunction

    // reference for enter built from R1-R5 and R7
    task automatic ref_enter(input logic [31:0] sp0, input logic [31:0] bp0,
                             input int lvl, input logic [15:0] sz,
                             input logic opw, input logic stkw, input logic fst);
        logic [31:0] sp, bp, fp, v;
        int nb;
        nb = opw ? 4 : 2;
        sp = sp0; bp = bp0;
        exp_wa.delete(); exp_wd.delete();
        sp = lo_keep(sp, sp - nb, stkw);
        exp_wa.push_back(nar(sp, stkw)); exp_wd.push_back(nar(bp, opw));
        fp = sp;
        exp_cyc = fst ? 14 : 10;
        exp_rd = 0; exp_wr = 1;
        if (lvl > 0) begin
            for (int i = 1; i < lvl; i++) begin
                bp = lo_keep(bp, bp - nb, opw);
                v  = nar(memval(nar(bp, opw)), opw);
                sp = lo_keep(sp, sp - nb, stkw);
                exp_wa.push_back(nar(sp, stkw)); exp_wd.push_back(v);
                exp_cyc += fst ? 3 : 4;
                exp_rd++; exp_wr++;
            end
            sp = lo_keep(sp, sp - nb, stkw);
            exp_wa.push_back(nar(sp, stkw)); exp_wd.push_back(nar(fp, opw));
            exp_cyc += fst ? 3 : 5;
            exp_wr++;
        end
        exp_bp = lo_keep(bp, fp, opw);
        exp_sp = lo_keep(sp, sp - {16'h0, sz}, stkw);
    endtask

    task automatic launch(input logic lv, input logic [31:0] sp0, input logic [31:0] bp0,
                          input logic [7:0] lvl, input logic [15:0] sz,
                          input logic opw, input logic stkw, input logic fst,
                          input int fat, input logic poke);
        @(negedge clk);
        acc_idx = 0; fault_at = fat;
        act_wa.delete(); act_wd.delete();
        op_leave = lv; sp_in = sp0; bp_in = bp0; nest_level = lvl;
        frame_size = sz; op_wide = opw; stk_wide = stkw; fast_core = fst;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            repeat (3) @(negedge clk);
            op_leave = 1'b1; sp_in = 32'hDEAD_0000; bp_in = 32'h0BAD_0000;
            nest_level = 8'd0; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
    endtask

    task automatic check_result(input string req, input logic want_fault);
        check(fault == want_fault, req, "fault flag", 32'(fault), 32'(want_fault));
        check(sp_out == exp_sp, req, "stack pointer", sp_out, exp_sp);
        check(bp_out == exp_bp, req, "base pointer", bp_out, exp_bp);
    endtask

    task automatic run_enter(input string req, input logic [31:0] sp0, input logic [31:0] bp0,
                             input int lvl, input logic [15:0] sz, input logic opw,
                             input logic stkw, input logic fst, input int fat,
                             input logic poke);
        logic trace_ok;
        ref_enter(sp0, bp0, lvl, sz, opw, stkw, fst);
        launch(1'b0, sp0, bp0, 8'(lvl), sz, opw, stkw, fst, fat, poke);
        if (fat >= 0) begin
            exp_sp = sp0; exp_bp = bp0;
            check_result(req, 1'b1);
        end else begin
            check_result(req, 1'b0);
            check(int'(cycles) == exp_cyc, req, "cycle cost", 32'(cycles), 32'(exp_cyc));
            check(int'(rd_count) == exp_rd, req, "read count", 32'(rd_count), 32'(exp_rd));
            check(int'(wr_count) == exp_wr, req, "write count", 32'(wr_count), 32'(exp_wr));
            trace_ok = (act_wa.size() == exp_wa.size());
            for (int i = 0; trace_ok && i < exp_wa.size(); i++)
                if (act_wa[i] != exp_wa[i] || act_wd[i] != exp_wd[i]) trace_ok = 1'b0;
            check(trace_ok, req, "write trace length", 32'(act_wa.size()), 32'(exp_wa.size()));
        end
    endtask

    task automatic run_leave(input string req, input logic [31:0] sp0, input logic [31:0] bp0,
                             input logic opw, input logic stkw, input int fat);
        logic [31:0] sp, v;
        sp = lo_keep(sp0, bp0, opw);
        v  = memval(nar(sp, stkw));
        launch(1'b1, sp0, bp0, 8'd0, 16'd0, opw, stkw, 1'b1, fat, 1'b0);
        if (fat >= 0) begin
            exp_sp = sp0; exp_bp = bp0;
            check_result(req, 1'b1);
        end else begin
            exp_sp = lo_keep(sp, sp + (opw ? 4 : 2), stkw);
            exp_bp = lo_keep(bp0, v, opw);
            check_result(req, 1'b0);
            check(cycles == 16'd4, req, "leave cost", 32'(cycles), 32'd4);
            check(act_wa.size() == 0, req, "leave writes", 32'(act_wa.size()), 32'd0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R11: reset state
        check(done == 1'b0 && fault == 1'b0, "R11", "done/fault after reset",
              {30'h0, done, fault}, 32'h0);
        check(mem_req == 1'b0, "R11", "mem_req after reset", 32'(mem_req), 32'h0);
        check(sp_out == 32'h0 && bp_out == 32'h0, "R11", "pointers after reset", sp_out, 32'h0);
        rst_n = 1'b1;

        // R1 R4: level 0, word operands, 16-bit stack
        run_enter("R1", 32'h1234_0100, 32'hABCD_0200, 0, 16'h0020, 1'b0, 1'b0, 1'b1, -1, 1'b0);
        // R2 R3 R7: level 3, wide, 32-bit stack, standard cost
        run_enter("R2", 32'h0010_0000, 32'h0020_0000, 3, 16'h0100, 1'b1, 1'b1, 1'b0, -1, 1'b0);
        // R3: level 1 pushes only base and frame pointers
        run_enter("R3", 32'h0000_8000, 32'h0000_9000, 1, 16'h0004, 1'b1, 1'b1, 1'b1, -1, 1'b0);
        // R5: 16-bit stack wraps across zero, upper half untouched
        run_enter("R5", 32'h5555_0002, 32'h7777_0010, 2, 16'h0010, 1'b1, 1'b0, 1'b1, -1, 1'b0);
        // R5: word operand base pointer wrap
        run_enter("R5", 32'h0003_4000, 32'h9999_0002, 3, 16'h0008, 1'b0, 1'b1, 1'b0, -1, 1'b0);
        // R7: level 255 boundary
        run_enter("R7", 32'h0040_0000, 32'h0080_0000, 255, 16'hFFFF, 1'b1, 1'b1, 1'b0, -1, 1'b0);
        run_enter("R7", 32'h0000_F000, 32'h0000_E000, 255, 16'h0002, 1'b0, 1'b0, 1'b1, -1, 1'b0);
        // R6: faults on first push, on a copy read, on the frame pointer push
        run_enter("R6", 32'h0010_0000, 32'h0020_0000, 3, 16'h0100, 1'b1, 1'b1, 1'b0, 0, 1'b0);
        run_enter("R6", 32'h0010_0000, 32'h0020_0000, 3, 16'h0100, 1'b1, 1'b1, 1'b0, 3, 1'b0);
        run_enter("R6", 32'h2222_0400, 32'h3333_0600, 2, 16'h0010, 1'b0, 1'b0, 1'b1, 3, 1'b0);
        // R10: second start in mid-sequence is ignored
        run_enter("R10", 32'h0010_0000, 32'h0020_0000, 3, 16'h0040, 1'b1, 1'b1, 1'b1, -1, 1'b1);
        // R8: leave, wide and word, and faulting pop
        run_leave("R8", 32'h0000_1000, 32'h0000_2000, 1'b1, 1'b1, -1);
        run_leave("R8", 32'h4444_1000, 32'h6666_FFFE, 1'b0, 1'b0, -1);
        run_leave("R8", 32'h0000_1000, 32'h0000_2000, 1'b1, 1'b1, 0);
        // R9: after completion the port is quiet
        @(negedge clk);
        check(mem_req == 1'b0, "R9", "mem_req when idle", 32'(mem_req), 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule